// File: doc/BRIEF.md
# ECC Error Statistics Register File

This block sits beside a memory ECC checker and keeps statistics on the errors it reports. Each cycle the checker may raise a correctable (single-bit) strobe, an uncorrectable (double-bit) strobe, or both, along with the faulting address. The block counts each error class in its own saturating counter. Each counter stops at a programmable limit. The block also records the address of a single-bit error.

Software reaches the block through a small word-addressed register port. It can enable counting, unmask the interrupt, pick whether the address register keeps the earliest or the latest single-bit error, program the two limits, and issue a clear. When an increment takes a counter up to its limit, a pending flag is set. The interrupt output is that flag gated by the interrupt enable. It stays high until a clear.

Top module: `ecc_errstat`

## Requirements
- R1: After reset the control word reads 0x00000001, both limits read 0x00000001, both counts and the captured address read 0, and irq is low.
- R2: Register select 0 is the control word, select 1 is the single-bit limit and select 2 is the double-bit limit. All three are writable and read back what was written. In the control word, bit 0 enables counting and capture, bit 1 enables the interrupt, bit 2 is the clear command and always reads 0, and bit 10 selects first-error capture. All other control bits read 0. Selects 6 and 7 read 0.
- R3: Select 3 (single-bit count), select 4 (double-bit count) and select 5 (captured address) are read-only. A write to them changes nothing.
- R4: With reg_rd high at a clock edge, reg_rdata shows the selected register after that edge. It holds its value while reg_rd is low.
- R5: Each counter adds one per strobe of its class while counting is enabled and the count is below its limit. It never counts past the limit. A limit of 0 keeps the counter at 0.
- R6: A single-bit and a double-bit strobe in the same cycle each advance their own counter in that cycle.
- R7: With control bit 0 low, strobes change neither counter nor the captured address.
- R8: With control bit 10 low, every enabled single-bit strobe loads err_addr into the captured address register, even after the counter has saturated.
- R9: With control bit 10 high, the first enabled single-bit strobe after a clear is captured, and later ones are ignored until the next clear.
- R10: A control write with bit 2 set zeroes both counts, the captured address and the interrupt pending flag at that edge. It wins over a strobe in the same cycle.
- R11: An increment that brings a counter equal to its limit sets a pending flag. irq is the pending flag ANDed with control bit 1. irq stays high until a clear, and a crossing taken while masked shows as soon as the mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbe_valid | input | 1 | Single-bit (corrected) error strobe |
| dbe_valid | input | 1 | Double-bit (uncorrectable) error strobe |
| err_addr | input | ADDR_W | Address of the reported error |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one clock after reg_rd |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can land in the same cycle. The first pair is a single-bit strobe together with a double-bit strobe. The second pair is any error strobe together with a clear written through the control word. The bench drives both inputs on the same falling edge. For the first pair, it reads both counts back and expects each to have advanced by exactly one. For the second pair, it expects the counts, the captured address and irq to be zero, which shows that the clear took priority. Around these cases, the bench sweeps every limit from 0 to 6 on both counters and compares each count and irq against the minimum of strobes applied and the limit.

// File: rtl/ecc_errstat_pkg.sv
package ecc_errstat_pkg;

    localparam int REG_W = 32;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL      = 3'd0,
        SEL_SBE_LIMIT = 3'd1,
        SEL_DBE_LIMIT = 3'd2,
        SEL_SBE_COUNT = 3'd3,
        SEL_DBE_COUNT = 3'd4,
        SEL_ERR_ADDR  = 3'd5
    } reg_sel_e;

    localparam int CB_COUNT_EN = 0;
    localparam int CB_IRQ_EN   = 1;
    localparam int CB_CLEAR    = 2;
    localparam int CB_FIRST    = 10;

    localparam int N_CLASS   = 2;
    localparam int CLASS_SBE = 0;
    localparam int CLASS_DBE = 1;

    typedef struct packed {
        logic first_only;
        logic irq_en;
        logic count_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{first_only: 1'b0, irq_en: 1'b0, count_en: 1'b1};

    function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.count_en   = w[CB_COUNT_EN];
        c.irq_en     = w[CB_IRQ_EN];
        c.first_only = w[CB_FIRST];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
        logic [REG_W-1:0] w;
        w              = '0;
        w[CB_COUNT_EN] = c.count_en;
        w[CB_IRQ_EN]   = c.irq_en;
        w[CB_FIRST]    = c.first_only;
        return w;
    endfunction

endpackage

// File: rtl/ecc_errstat_satcnt.sv
module ecc_errstat_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         enable,
    input  logic         strobe,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         reach
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;
    logic         bump;

    assign cnt_inc = cnt_q + W'(1);
    assign bump    = enable && strobe && (cnt_q < limit);
    assign reach   = bump && (cnt_inc == limit);
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (bump) begin
            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/ecc_errstat_addrcap.sv
module ecc_errstat_addrcap #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          enable,
    input  logic          strobe,
    input  logic          first_only,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_q,
    output logic          held
);

    logic take;

    assign take = enable && strobe && !(first_only && held);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr_q <= '0;
            held   <= 1'b0;
        end else if (take) begin
            addr_q <= addr_in;
            held   <= 1'b1;
        end
    end

endmodule

// File: rtl/ecc_errstat_csr.sv
module ecc_errstat_csr
    import ecc_errstat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [SEL_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [CNT_W-1:0]  sbe_count,
    input  logic [CNT_W-1:0]  dbe_count,
    input  logic [ADDR_W-1:0] cap_addr,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  sbe_limit,
    output logic [CNT_W-1:0]  dbe_limit,
    output logic              clr,
    output logic [REG_W-1:0]  reg_rdata
);

    logic [REG_W-1:0] rd_mux;

    assign clr = reg_wr && (reg_addr == SEL_CTRL) && reg_wdata[CB_CLEAR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= CTRL_RESET;
            sbe_limit <= CNT_W'(1);
            dbe_limit <= CNT_W'(1);
        end else if (reg_wr) begin
            case (reg_addr)
                SEL_CTRL:      ctrl      <= ctrl_unpack(reg_wdata);
                SEL_SBE_LIMIT: sbe_limit <= CNT_W'(reg_wdata);
                SEL_DBE_LIMIT: dbe_limit <= CNT_W'(reg_wdata);
                default:       ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            SEL_CTRL:      rd_mux = ctrl_pack(ctrl);
            SEL_SBE_LIMIT: rd_mux = REG_W'(sbe_limit);
            SEL_DBE_LIMIT: rd_mux = REG_W'(dbe_limit);
            SEL_SBE_COUNT: rd_mux = REG_W'(sbe_count);
            SEL_DBE_COUNT: rd_mux = REG_W'(dbe_count);
            SEL_ERR_ADDR:  rd_mux = REG_W'(cap_addr);
            default:       rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/ecc_errstat.sv
module ecc_errstat
    import ecc_errstat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sbe_valid,
    input  logic              dbe_valid,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    ctrl_t              ctl;
    logic               clr_pulse;
    logic               ctl_count_en;
    logic               ctl_irq_en;
    logic               ctl_first;
    logic [CNT_W-1:0]   sbe_lim;
    logic [CNT_W-1:0]   dbe_lim;
    logic [CNT_W-1:0]   sbe_cnt;
    logic [CNT_W-1:0]   dbe_cnt;
    logic [ADDR_W-1:0]  cap_addr;
    logic               cap_held;
    logic               pend_q;

    logic [N_CLASS-1:0] strobe_v;
    logic [N_CLASS-1:0] reach_v;
    logic [CNT_W-1:0]   lim_v [N_CLASS];
    logic [CNT_W-1:0]   cnt_v [N_CLASS];

    assign ctl_count_en = ctl.count_en;
    assign ctl_irq_en   = ctl.irq_en;
    assign ctl_first    = ctl.first_only;

    ecc_errstat_csr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .sbe_count (sbe_cnt),
        .dbe_count (dbe_cnt),
        .cap_addr  (cap_addr),
        .ctrl      (ctl),
        .sbe_limit (sbe_lim),
        .dbe_limit (dbe_lim),
        .clr       (clr_pulse),
        .reg_rdata (reg_rdata)
    );

    assign strobe_v[CLASS_SBE] = sbe_valid;
    assign strobe_v[CLASS_DBE] = dbe_valid;
    assign lim_v[CLASS_SBE]    = sbe_lim;
    assign lim_v[CLASS_DBE]    = dbe_lim;
    assign sbe_cnt             = cnt_v[CLASS_SBE];
    assign dbe_cnt             = cnt_v[CLASS_DBE];

    for (genvar g = 0; g < N_CLASS; g++) begin : g_class
        ecc_errstat_satcnt #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr_pulse),
            .enable (ctl_count_en),
            .strobe (strobe_v[g]),
            .limit  (lim_v[g]),
            .count  (cnt_v[g]),
            .reach  (reach_v[g])
        );
    end

    ecc_errstat_addrcap #(.AW(ADDR_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_pulse),
        .enable     (ctl_count_en),
        .strobe     (sbe_valid),
        .first_only (ctl_first),
        .addr_in    (err_addr),
        .addr_q     (cap_addr),
        .held       (cap_held)
    );

    always_ff @(posedge clk) begin
        if (rst || clr_pulse) begin
            pend_q <= 1'b0;
        end else if (|reach_v) begin
            pend_q <= 1'b1;
        end
    end

    assign irq = pend_q && ctl_irq_en;

endmodule

// File: rtl/ecc_errstat_chk.sv
module ecc_errstat_chk #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              sbe_valid,
    input logic              dbe_valid,
    input logic [ADDR_W-1:0] err_addr,
    input logic              irq,
    input logic              clr,
    input logic              count_en,
    input logic              irq_en,
    input logic              first_only,
    input logic [CNT_W-1:0]  sbe_cnt,
    input logic [CNT_W-1:0]  dbe_cnt,
    input logic [CNT_W-1:0]  sbe_lim,
    input logic [CNT_W-1:0]  dbe_lim,
    input logic [ADDR_W-1:0] cap_addr,
    input logic              cap_held
);

    a_r5_sbe_step: assert property (@(posedge clk) disable iff (rst)
        (sbe_cnt != $past(sbe_cnt)) |-> (sbe_cnt == $past(sbe_cnt) + CNT_W'(1) || sbe_cnt == '0));

    a_r5_dbe_step: assert property (@(posedge clk) disable iff (rst)
        (dbe_cnt != $past(dbe_cnt)) |-> (dbe_cnt == $past(dbe_cnt) + CNT_W'(1) || dbe_cnt == '0));

    a_r5_sbe_stop: assert property (@(posedge clk) disable iff (rst)
        (sbe_cnt >= sbe_lim) |=> (sbe_cnt == $past(sbe_cnt) || sbe_cnt == '0));

    a_r5_dbe_stop: assert property (@(posedge clk) disable iff (rst)
        (dbe_cnt >= dbe_lim) |=> (dbe_cnt == $past(dbe_cnt) || dbe_cnt == '0));

    a_r6_both_advance: assert property (@(posedge clk) disable iff (rst)
        (count_en && sbe_valid && dbe_valid && !clr && sbe_cnt < sbe_lim && dbe_cnt < dbe_lim)
        |=> (sbe_cnt == $past(sbe_cnt) + CNT_W'(1) && dbe_cnt == $past(dbe_cnt) + CNT_W'(1)));

    a_r7_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !clr) |=> ($stable(sbe_cnt) && $stable(dbe_cnt) && $stable(cap_addr)));

    a_r8_last_follows: assert property (@(posedge clk) disable iff (rst)
        (count_en && sbe_valid && !first_only && !clr) |=> (cap_addr == $past(err_addr)));

    a_r9_first_holds: assert property (@(posedge clk) disable iff (rst)
        (first_only && cap_held && !clr) |=> $stable(cap_addr));

    a_r10_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sbe_cnt == '0 && dbe_cnt == '0 && cap_addr == '0 && !irq));

    a_r11_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        irq |=> (irq || $past(clr) || !irq_en));

endmodule

bind ecc_errstat ecc_errstat_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sbe_valid  (sbe_valid),
    .dbe_valid  (dbe_valid),
    .err_addr   (err_addr),
    .irq        (irq),
    .clr        (clr_pulse),
    .count_en   (ctl_count_en),
    .irq_en     (ctl_irq_en),
    .first_only (ctl_first),
    .sbe_cnt    (sbe_cnt),
    .dbe_cnt    (dbe_cnt),
    .sbe_lim    (sbe_lim),
    .dbe_lim    (dbe_lim),
    .cap_addr   (cap_addr),
    .cap_held   (cap_held)
);

// File: tb/sim_ecc_errstat.sv
module sim_ecc_errstat;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] C_EN    = 32'h1;
    localparam logic [31:0] C_IE    = 32'h2;
    localparam logic [31:0] C_CLR   = 32'h4;
    localparam logic [31:0] C_FIRST = 32'h400;

    logic        clk = 1'b0;
    logic        rst;
    logic        sbe_valid, dbe_valid;
    logic [31:0] err_addr;
    logic        reg_wr, reg_rd;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ecc_errstat u0 (
        .clk(clk), .rst(rst), .sbe_valid(sbe_valid), .dbe_valid(dbe_valid),
        .err_addr(err_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic err(input logic s, input logic d, input logic [31:0] a);
        @(negedge clk);
        sbe_valid = s; dbe_valid = d; err_addr = a;
        @(negedge clk);
        sbe_valid = 1'b0; dbe_valid = 1'b0;
    endtask

    task automatic sweep(input bit dbe_side, input int lim);
        logic [31:0] v;
        int          exp_n;
        wr(dbe_side ? 3'd2 : 3'd1, lim);
        wr(dbe_side ? 3'd1 : 3'd2, 32'd200);
        wr(3'd0, C_EN | C_IE | C_CLR);
        for (int k = 1; k <= lim + 2; k++) begin
            err(!dbe_side, dbe_side, 32'h1000 + k);
            exp_n = (k < lim) ? k : lim;
            rd(dbe_side ? 3'd4 : 3'd3, v);
            chk($sformatf("R5 count side=%0d lim=%0d k=%0d", dbe_side, lim, k), v, exp_n);
            chk($sformatf("R11 irq side=%0d lim=%0d k=%0d", dbe_side, lim, k),
                {31'd0, irq}, {31'd0, (lim != 0 && k >= lim)});
        end
        rd(dbe_side ? 3'd3 : 3'd4, v);
        chk($sformatf("R5 other count untouched side=%0d", dbe_side), v, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog all requirements: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; sbe_valid = 1'b0; dbe_valid = 1'b0; err_addr = '0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        chk("R1 irq", {31'd0, irq}, 0);
        rd(3'd0, v); chk("R1 ctrl", v, 32'h1);
        rd(3'd1, v); chk("R1 sbe limit", v, 1);
        rd(3'd2, v); chk("R1 dbe limit", v, 1);
        rd(3'd3, v); chk("R1 sbe count", v, 0);
        rd(3'd4, v); chk("R1 dbe count", v, 0);
        rd(3'd5, v); chk("R1 addr", v, 0);

        // R2 read/write registers, undefined bits and selects
        wr(3'd1, 32'hDEAD_0007); rd(3'd1, v); chk("R2 sbe limit rw", v, 32'hDEAD_0007);
        wr(3'd2, 32'h0000_0033); rd(3'd2, v); chk("R2 dbe limit rw", v, 32'h33);
        wr(3'd0, 32'hFFFF_FFFB); rd(3'd0, v); chk("R2 ctrl defined bits", v, 32'h403);
        rd(3'd6, v); chk("R2 select 6", v, 0);
        rd(3'd7, v); chk("R2 select 7", v, 0);
        wr(3'd0, C_EN);

        // R4 read data holds when reg_rd is low
        rd(3'd2, v);
        @(negedge clk); @(negedge clk);
        chk("R4 rdata held", reg_rdata, 32'h33);
        @(negedge clk); reg_addr = 3'd1;
        @(negedge clk);
        chk("R4 rdata held after select change", reg_rdata, 32'h33);

        // R3 read-only registers ignore writes
        wr(3'd1, 5); err(1'b1, 1'b1, 32'h55);
        wr(3'd3, 32'h99); wr(3'd4, 32'h99); wr(3'd5, 32'h99);
        rd(3'd3, v); chk("R3 sbe count ro", v, 1);
        rd(3'd4, v); chk("R3 dbe count ro", v, 1);
        rd(3'd5, v); chk("R3 addr ro", v, 32'h55);

        // R5 R11 limit sweeps on both classes
        for (int lim = 0; lim <= 6; lim++) begin
            sweep(1'b0, lim);
            sweep(1'b1, lim);
        end

        // R6 simultaneous strobes
        wr(3'd1, 10); wr(3'd2, 10); wr(3'd0, C_EN | C_CLR);
        for (int k = 1; k <= 3; k++) err(1'b1, 1'b1, 32'h2000 + k);
        rd(3'd3, v); chk("R6 sbe with dbe", v, 3);
        rd(3'd4, v); chk("R6 dbe with sbe", v, 3);

        // R7 counting disabled
        wr(3'd0, 32'h0);
        err(1'b1, 1'b1, 32'h7777);
        rd(3'd3, v); chk("R7 sbe frozen", v, 3);
        rd(3'd4, v); chk("R7 dbe frozen", v, 3);
        rd(3'd5, v); chk("R7 addr frozen", v, 32'h2003);

        // R8 last-error capture, also past saturation
        wr(3'd1, 2); wr(3'd0, C_EN | C_CLR);
        for (int k = 0; k < 5; k++) begin
            err(1'b1, 1'b0, 32'hA000 + 3 * k);
            rd(3'd5, v); chk($sformatf("R8 last addr k=%0d", k), v, 32'hA000 + 3 * k);
        end
        err(1'b0, 1'b1, 32'hBBBB);
        rd(3'd5, v); chk("R8 dbe does not load addr", v, 32'hA00C);

        // R9 first-error capture
        wr(3'd0, C_EN | C_FIRST | C_CLR);
        rd(3'd5, v); chk("R9 cleared before first", v, 0);
        err(1'b1, 1'b0, 32'hC001);
        err(1'b1, 1'b0, 32'hC002);
        err(1'b1, 1'b0, 32'hC003);
        rd(3'd5, v); chk("R9 first kept", v, 32'hC001);
        wr(3'd0, C_EN | C_FIRST | C_CLR);
        err(1'b1, 1'b0, 32'hC0FF);
        err(1'b1, 1'b0, 32'hC100);
        rd(3'd5, v); chk("R9 first after clear", v, 32'hC0FF);

        // R10 clear together with strobes
        wr(3'd0, C_EN | C_IE);
        wr(3'd1, 1); err(1'b1, 1'b0, 32'hD0);
        chk("R10 irq set before clear", {31'd0, irq}, 1);
        @(negedge clk);
        sbe_valid = 1'b1; dbe_valid = 1'b1; err_addr = 32'hD1;
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = C_EN | C_IE | C_CLR;
        @(negedge clk);
        sbe_valid = 1'b0; dbe_valid = 1'b0; reg_wr = 1'b0;
        chk("R10 irq cleared", {31'd0, irq}, 0);
        rd(3'd3, v); chk("R10 sbe cleared", v, 0);
        rd(3'd4, v); chk("R10 dbe cleared", v, 0);
        rd(3'd5, v); chk("R10 addr cleared", v, 0);
        rd(3'd0, v); chk("R10 clear bit reads 0", v, 32'h3);

        // R11 crossing while masked, then unmasked
        wr(3'd0, C_EN | C_CLR); wr(3'd2, 2);
        err(1'b0, 1'b1, 0); err(1'b0, 1'b1, 0);
        chk("R11 masked irq low", {31'd0, irq}, 0);
        wr(3'd0, C_EN | C_IE);
        chk("R11 pending shows when unmasked", {31'd0, irq}, 1);
        repeat (4) @(negedge clk);
        chk("R11 irq level held", {31'd0, irq}, 1);
        wr(3'd0, C_EN | C_IE | C_CLR);
        chk("R11 irq dropped by clear", {31'd0, irq}, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule